// File: doc/BRIEF.md
# Memory-Mapped Console Controller

This block is a bus-slave peripheral that claims the top 64 KB of a 32-bit address space and holds four console registers in it. Two registers serve keyboard-style input and two serve display-style output. Keystrokes arrive on a valid/ready byte stream and wait in a circular buffer. The processor polls an input-ready flag and then reads an input data register. Each such read returns the oldest byte and removes it from the buffer.

On the output side, the processor polls an output-ready flag and then writes a byte. That byte is driven onto a display port with a one-cycle valid strobe. The port then stays busy for a programmable number of cycles, which stands in for the time the display needs to consume the byte. Neither stream handshakes back-pressure at the display port, so the display must take every strobe.

The key stream follows these back-pressure rules. `key_ready` is high whenever the buffer has a free slot, and a byte is taken on any edge where `key_valid` and `key_ready` are both high. A byte offered while `key_ready` is low is not held or retried. It is dropped and recorded in an overrun flag. Bus strobes last one cycle. Read data is combinational in the same cycle as `bus_rd`, and any side effect of the access takes effect at the following clock edge.

Top module: `console_mmio`

## Requirements
- R1: `bus_sel` is high only when `bus_rd` or `bus_wr` is high and `bus_addr[31:16]` is 0xFFFF. An access outside that window returns `bus_rdata` = 0 and changes no state.
- R2: The word offsets inside the window are fixed. 0x0 is input control, 0x4 is input data, 0x8 is output control and 0xC is output data. Reads of any other offset, and reads of output data, return 0. Writes to anything other than output data are ignored.
- R3: Input control reads bit 0 = byte available and bit 1 = overrun. Output control reads bit 0 = output ready. Every other bit of both registers reads 0.
- R4: `key_ready` is 1 exactly when fewer than DEPTH bytes are buffered. Accepted bytes are returned in arrival order.
- R5: A read of input data returns the oldest byte in bits 7:0, zero-extended, and removes it from the buffer. A read of input data when the buffer is empty returns 0 and removes nothing.
- R6: A key offered while the buffer is full is dropped and sets the overrun flag. The flag stays set until a read of input control, which still returns it as 1.
- R7: A key accepted and an input data read in the same cycle both take effect. Key acceptance is judged on the buffer state before the edge.
- R8: The internal front and back counters return to zero whenever they become equal. First-in, first-out order therefore holds across any number of index wraps, even when the counters wrap.
- R9: A write to output data while output ready is 1 drives `wdata[7:0]` on `disp_data`. It also raises `disp_valid` for exactly one cycle after the edge and holds output ready at 0 for DISPLAY_DELAY cycles before it returns to 1.
- R10: A write to output data while output ready is 0 is ignored: no strobe is produced and `disp_data` is unchanged.
- R11: After reset the buffer is empty, overrun is 0, output ready is 1 and `disp_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| bus_addr | input | 32 | Byte address of the access |
| bus_rd | input | 1 | Single-cycle read strobe |
| bus_wr | input | 1 | Single-cycle write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the strobe cycle |
| bus_sel | output | 1 | Access is claimed by this peripheral |
| key_valid | input | 1 | Keystroke byte offered |
| key_data | input | 8 | Keystroke byte |
| key_ready | output | 1 | Buffer has a free slot |
| disp_valid | output | 1 | One-cycle strobe for a new display byte |
| disp_data | output | 8 | Display byte, held until the next accepted write |

## Verification
The bench builds the block with DEPTH = 4, a 6-bit counter width and DISPLAY_DELAY = 5. The small depth puts the full buffer, the dropped key and the overrun flag within a handful of pushes. The 6-bit counters let a long stretch of alternating pushes and pops, in which the buffer never fully drains, carry the front counter past its wrap, so slot indexing across the wrap is exercised. The short delay allows the exact busy window to be counted cycle by cycle, including a write rejected in the middle of it.

// File: rtl/console_mmio_pkg.sv
package console_mmio_pkg;

  localparam logic [15:0] WINDOW_TAG = 16'hFFFF;

  typedef enum logic [1:0] {
    REG_IN_CTRL  = 2'd0,
    REG_IN_DATA  = 2'd1,
    REG_OUT_CTRL = 2'd2,
    REG_OUT_DATA = 2'd3
  } reg_sel_e;

  typedef struct packed {
    logic     in_win;
    logic     mapped;
    reg_sel_e which;
  } decode_t;

endpackage

// File: rtl/cmio_decode.sv
module cmio_decode
  import console_mmio_pkg::*;
(
  input  logic [31:0] addr,
  output decode_t     dec
);
  always_comb begin
    dec.in_win = (addr[31:16] == WINDOW_TAG);
    dec.mapped = (addr[15:4] == 12'h000) && (addr[1:0] == 2'b00);
    dec.which  = reg_sel_e'(addr[3:2]);
  end
endmodule

// File: rtl/cmio_key_ring.sv
module cmio_key_ring #(
  parameter int DEPTH = 16,
  parameter int CNT_W = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          key_valid,
  input  logic [DW-1:0] key_data,
  output logic          key_ready,
  input  logic          pop_req,
  input  logic          ovr_clr,
  output logic [DW-1:0] head_byte,
  output logic          avail,
  output logic          overrun
);
  localparam int IDX_W = $clog2(DEPTH);

  logic [DW-1:0]    slots [DEPTH];
  logic [CNT_W-1:0] front, back, occ, front_nx, back_nx;
  logic             push, pop;

  assign occ       = front - back;
  assign key_ready = (occ < CNT_W'(DEPTH));
  assign avail     = (front != back);
  assign push      = key_valid && key_ready;
  assign pop       = pop_req && avail;
  assign head_byte = avail ? slots[back[IDX_W-1:0]] : '0;

  always_comb begin
    front_nx = front + CNT_W'(push);
    back_nx  = back + CNT_W'(pop);
    if (front_nx == back_nx) begin
      front_nx = '0;
      back_nx  = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (push) slots[front[IDX_W-1:0]] <= key_data;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      front   <= '0;
      back    <= '0;
      overrun <= 1'b0;
    end else begin
      front <= front_nx;
      back  <= back_nx;
      if (key_valid && !key_ready) overrun <= 1'b1;
      else if (ovr_clr)            overrun <= 1'b0;
    end
  end

  // R4
  occ_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    occ <= CNT_W'(DEPTH));

  // R8
  eq_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (front == back) |-> (front == '0));

  // R7
  both_move_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && pop) |=> (occ == $past(occ)));

  // R6
  drop_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (key_valid && !key_ready) |=> overrun);
endmodule

// File: rtl/cmio_disp_chan.sv
module cmio_disp_chan #(
  parameter int DELAY = 16,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_req,
  input  logic [DW-1:0] wr_byte,
  output logic          out_ready,
  output logic          disp_valid,
  output logic [DW-1:0] disp_data
);
  localparam int CW = $clog2(DELAY + 1);

  logic [CW-1:0] cnt;
  logic          accept;

  assign accept = wr_req && out_ready;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_ready  <= 1'b1;
      disp_valid <= 1'b0;
      disp_data  <= '0;
      cnt        <= '0;
    end else begin
      disp_valid <= 1'b0;
      if (accept) begin
        disp_data  <= wr_byte;
        disp_valid <= 1'b1;
        out_ready  <= 1'b0;
        cnt        <= CW'(DELAY - 1);
      end else if (!out_ready) begin
        if (cnt == '0) out_ready <= 1'b1;
        else           cnt <= cnt - 1'b1;
      end
    end
  end

  // R9
  pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> (disp_valid && !out_ready && disp_data == $past(wr_byte)));

  // R9
  one_shot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    disp_valid |=> !disp_valid);

  // R10
  busy_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_req && !out_ready) |=> (!disp_valid && $stable(disp_data)));
endmodule

// File: rtl/console_mmio.sv
module console_mmio
  import console_mmio_pkg::*;
#(
  parameter int DEPTH         = 16,
  parameter int CNT_W         = 16,
  parameter int DISPLAY_DELAY = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [31:0] bus_addr,
  input  logic        bus_rd,
  input  logic        bus_wr,
  input  logic [31:0] bus_wdata,
  output logic [31:0] bus_rdata,
  output logic        bus_sel,
  input  logic        key_valid,
  input  logic [7:0]  key_data,
  output logic        key_ready,
  output logic        disp_valid,
  output logic [7:0]  disp_data
);
  decode_t    dec;
  logic       hit_rd, hit_wr;
  logic       avail, overrun, out_ready;
  logic [7:0] head_byte;

  cmio_decode u_dec (.addr(bus_addr), .dec(dec));

  assign bus_sel = dec.in_win && (bus_rd || bus_wr);
  assign hit_rd  = bus_rd && dec.in_win && dec.mapped;
  assign hit_wr  = bus_wr && dec.in_win && dec.mapped;

  cmio_key_ring #(.DEPTH(DEPTH), .CNT_W(CNT_W), .DW(8)) u_ring (
    .clk(clk), .rst_n(rst_n),
    .key_valid(key_valid), .key_data(key_data), .key_ready(key_ready),
    .pop_req(hit_rd && dec.which == REG_IN_DATA),
    .ovr_clr(hit_rd && dec.which == REG_IN_CTRL),
    .head_byte(head_byte), .avail(avail), .overrun(overrun)
  );

  cmio_disp_chan #(.DELAY(DISPLAY_DELAY), .DW(8)) u_disp (
    .clk(clk), .rst_n(rst_n),
    .wr_req(hit_wr && dec.which == REG_OUT_DATA),
    .wr_byte(bus_wdata[7:0]),
    .out_ready(out_ready), .disp_valid(disp_valid), .disp_data(disp_data)
  );

  always_comb begin
    bus_rdata = '0;
    if (hit_rd) begin
      case (dec.which)
        REG_IN_CTRL:  bus_rdata = {30'd0, overrun, avail};
        REG_IN_DATA:  bus_rdata = {24'd0, head_byte};
        REG_OUT_CTRL: bus_rdata = {31'd0, out_ready};
        default:      bus_rdata = '0;
      endcase
    end
  end

  // R1
  quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0));
endmodule

// File: tb/sim_console_mmio.sv
module sim_console_mmio;
  localparam int DEPTH = 4;
  localparam int DLY   = 5;
  localparam logic [31:0] A_ICTL = 32'hFFFF_0000;
  localparam logic [31:0] A_IDAT = 32'hFFFF_0004;
  localparam logic [31:0] A_OCTL = 32'hFFFF_0008;
  localparam logic [31:0] A_ODAT = 32'hFFFF_000C;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic        rst_n = 1'b0;
  logic [31:0] bus_addr = '0, bus_wdata = '0, bus_rdata;
  logic        bus_rd = 1'b0, bus_wr = 1'b0, bus_sel;
  logic        key_valid = 1'b0, key_ready, disp_valid;
  logic [7:0]  key_data = '0, disp_data;

  console_mmio #(.DEPTH(DEPTH), .CNT_W(6), .DISPLAY_DELAY(DLY)) u0 (
    .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_rd(bus_rd),
    .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .bus_sel(bus_sel), .key_valid(key_valid), .key_data(key_data),
    .key_ready(key_ready), .disp_valid(disp_valid), .disp_data(disp_data)
  );

  int n_chk = 0, n_fail = 0;
  logic [7:0] keyq[$];
  logic [7:0] dispq[$];
  bit ovr_m = 1'b0;
  bit done = 1'b0;

  task automatic chk_eq(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic bus_read(input logic [31:0] a, output logic [31:0] d, output logic s);
    @(negedge clk);
    bus_addr = a; bus_rd = 1'b1;
    #1 d = bus_rdata; s = bus_sel;
    @(posedge clk); #1 bus_rd = 1'b0;
  endtask

  task automatic bus_write(input logic [31:0] a, input logic [31:0] w);
    @(negedge clk);
    bus_addr = a; bus_wdata = w; bus_wr = 1'b1;
    @(posedge clk); #1 bus_wr = 1'b0;
  endtask

  task automatic push_key(input logic [7:0] k);
    bit acc;
    @(negedge clk);
    key_valid = 1'b1; key_data = k;
    acc = (keyq.size() < DEPTH);
    #1 chk_eq("R4 key_ready", {31'd0, key_ready}, {31'd0, acc});
    if (acc) keyq.push_back(k); else ovr_m = 1'b1;
    @(posedge clk); #1 key_valid = 1'b0;
  endtask

  task automatic read_ictl(input string tag);
    logic [31:0] d; logic s;
    bus_read(A_ICTL, d, s);
    chk_eq(tag, d, {30'd0, ovr_m, keyq.size() != 0});
    ovr_m = 1'b0;
  endtask

  task automatic read_idat(input string tag);
    logic [31:0] d; logic s; logic [7:0] e;
    e = (keyq.size() != 0) ? keyq.pop_front() : 8'h00;
    bus_read(A_IDAT, d, s);
    chk_eq(tag, d, {24'd0, e});
  endtask

  task automatic push_and_pop(input logic [7:0] k);
    logic [31:0] d; logic [7:0] e; bit acc;
    @(negedge clk);
    key_valid = 1'b1; key_data = k; bus_addr = A_IDAT; bus_rd = 1'b1;
    acc = (keyq.size() < DEPTH);
    e = (keyq.size() != 0) ? keyq.pop_front() : 8'h00;
    if (acc) keyq.push_back(k); else ovr_m = 1'b1;
    #1 d = bus_rdata;
    chk_eq("R7 simultaneous read data", d, {24'd0, e});
    @(posedge clk); #1 key_valid = 1'b0; bus_rd = 1'b0;
  endtask

  // scoreboard monitor for the display stream
  always @(negedge clk) begin
    if (rst_n && disp_valid) begin
      if (dispq.size() == 0) chk_eq("R10 unexpected display strobe", 32'd1, 32'd0);
      else chk_eq("R9 display byte", {24'd0, disp_data}, {24'd0, dispq.pop_front()});
    end
  end

  initial begin
    #(4 * 100000);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [31:0] d; logic s; int zeros;
    repeat (3) @(posedge clk);
    @(negedge clk) rst_n = 1'b1;

    // R11 reset state
    #1 chk_eq("R11 disp_valid", {31'd0, disp_valid}, 32'd0);
    chk_eq("R11 key_ready", {31'd0, key_ready}, 32'd1);
    read_ictl("R11 input control after reset");
    bus_read(A_OCTL, d, s);
    chk_eq("R11 output ready after reset", d, 32'd1);
    chk_eq("R1 select inside window", {31'd0, s}, 32'd1);

    // R1 outside window
    push_key(8'h33);
    bus_read(32'h0000_0004, d, s);
    chk_eq("R1 sel outside", {31'd0, s}, 32'd0);
    chk_eq("R1 rdata outside", d, 32'd0);
    bus_write(32'h0000_000C, 32'h99);
    read_idat("R1 byte kept after outside read");

    // R2 unmapped offsets, ignored writes
    push_key(8'h44);
    bus_read(32'hFFFF_0010, d, s);
    chk_eq("R2 offset 0x10", d, 32'd0);
    bus_read(32'hFFFF_0006, d, s);
    chk_eq("R2 misaligned offset", d, 32'd0);
    bus_read(A_ODAT, d, s);
    chk_eq("R2 output data reads zero", d, 32'd0);
    bus_write(A_IDAT, 32'h55);
    bus_write(A_ICTL, 32'hFF);
    read_ictl("R3 input control bit0 only");
    read_idat("R2 data intact after ignored writes");

    // R4 R5 ordering
    push_key(8'hA1); push_key(8'hB2); push_key(8'hC3);
    read_ictl("R3 ready set");
    read_idat("R5 first"); read_idat("R5 second"); read_idat("R5 third");
    read_ictl("R3 ready clear");
    read_idat("R5 empty read zero");

    // R6 full and overrun
    for (int i = 0; i < DEPTH; i++) push_key(8'h10 + 8'(i));
    push_key(8'hEE);
    read_ictl("R6 overrun and ready");
    read_ictl("R6 overrun cleared by read");

    // R7 full with simultaneous pop: key dropped
    push_and_pop(8'hF0);
    read_ictl("R7 overrun on full-cycle push");
    while (keyq.size() != 0) read_idat("R5 drain");

    // R7 normal simultaneous push and pop
    push_key(8'h61); push_key(8'h62);
    push_and_pop(8'h63);
    push_and_pop(8'h64);
    while (keyq.size() != 0) read_idat("R7 order after simultaneous");
    push_and_pop(8'h65);
    read_idat("R7 push into empty with read");

    // R8 long run with wrap, buffer never empty
    push_key(8'h01);
    for (int i = 0; i < 80; i++) begin
      push_key(8'(i + 2));
      read_idat("R8 order across wrap");
    end
    read_idat("R8 last");
    read_ictl("R8 empty at end");

    // R9 R10 display channel
    dispq.push_back(8'h41);
    bus_write(A_ODAT, 32'hABCD_0041);
    bus_write(A_ODAT, 32'h7E);
    zeros = 1;
    for (int i = 0; i < 40; i++) begin
      bus_read(A_OCTL, d, s);
      if (d[0]) break;
      zeros++;
    end
    chk_eq("R9 busy cycles", zeros, DLY);
    chk_eq("R10 disp_data held", {24'd0, disp_data}, 32'h41);
    dispq.push_back(8'h5A);
    bus_write(A_ODAT, 32'h5A);
    bus_read(A_OCTL, d, s);
    chk_eq("R9 busy right after write", d, 32'd0);
    repeat (DLY + 2) @(posedge clk);
    #1 chk_eq("R9 all strobes seen", dispq.size(), 32'd0);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule